// File: doc/BRIEF.md
# Multi-dimensional element index remapper

This block turns the linear step number of a vector loop into a reordered element index. Software programs a shape of up to three dimensions (x, y, z), a code that chooses which dimension runs innermost and which outermost, an element offset and a maximum vector length. The block treats the step as a position inside the nested x/y/z loops taken in the chosen order. It rebuilds a row-major element number from the resulting coordinates, adds the offset and folds the sum into the maximum vector length. A shape that covers fewer elements than the vector length is legal. In that case the index sequence wraps and repeats on purpose, for example so that one group of registers can act as an accumulator.

The step lives in a counter. A loop controller advances the counter once per element. After an interrupt the controller can load any step directly, and the loop resumes with no replay. Each request, whether a load or an advance, produces one registered result two clock edges later. The result is the remapped index, a one-cycle valid strobe and an overrun flag. The overrun flag reports that a base register number plus the index runs past the end of the register file.

Top module: `elem_remap`

## Requirements
- R1: While reset is held and after it is released, `valid_o`, `idx_o` and `overrun_o` are all 0 until the first request.
- R2: A cycle with `load_i` or `advance_i` high is a request. Its result appears with `valid_o` high after exactly two rising edges. `valid_o` is high for one cycle per request and is low in every other cycle. Requests may be issued back to back.
- R3: Each dimension field holds its size minus one. The shape covers (xdim+1)*(ydim+1)*(zdim+1) elements, and the step is reduced modulo that total before use, so the sequence wraps.
- R4: `perm_i` selects the nesting, listed from inner to outer loop: 000 x,y,z; 001 x,z,y; 010 y,x,z; 011 y,z,x; 100 z,x,y; 101 z,y,x. Codes 110 and 111 behave as 000.
- R5: Coordinates are found by counting the innermost dimension fastest. The element number is x + X*y + X*Y*z, where X and Y are the x and y sizes.
- R6: `idx_o` = (element number + `offset_i`) mod `maxlen_i`, with `maxlen_i` in 1..64.
- R7: With code 000 the element order equals the step order, still reduced modulo the shape total and `maxlen_i`.
- R8: When at least two dimension fields are 0, every permutation code yields the plain step order.
- R9: A 4x4 shape (fields 3,3,0) with y innermost (code 010) and `maxlen_i`=4 yields 0,0,0,0,1,1,1,1,2,2,2,2,3,3,3,3 over steps 0..15.
- R10: A 4x1 shape (fields 3,0,0) with code 000 yields 0,1,2,3 repeated over steps 0..15.
- R11: `overrun_o` is 1 exactly when `base_i` + `idx_o` exceeds NREGS-1 (63 by default). It is updated together with `idx_o`.
- R12: `idx_o` and `overrun_o` hold their values in every cycle that follows a cycle without a request.
- R13: A load sets the step to `load_step_i`, and load wins over a simultaneous advance. An advance adds one. Loading step k gives the same result as advancing to k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Load the step counter from `load_step_i` |
| advance_i | input | 1 | Increment the step counter |
| load_step_i | input | STEP_W (10) | Step value to load |
| xdim_i | input | DIM_W (3) | x size minus one |
| ydim_i | input | DIM_W (3) | y size minus one |
| zdim_i | input | DIM_W (3) | z size minus one |
| perm_i | input | 3 | Nesting order code |
| offset_i | input | IDX_W (6) | Offset added to the element number |
| maxlen_i | input | IDX_W+1 (7) | Maximum vector length, 1..64 |
| base_i | input | REG_W (7) | Base register number for the overrun test |
| idx_o | output | IDX_W (6) | Remapped element index |
| valid_o | output | 1 | Result strobe |
| overrun_o | output | 1 | Base plus index is past the register file |

## Verification
The assertions assume three things about the inputs. `maxlen_i` is never zero. The shape, permutation, offset, length and base stay constant from a request until its result appears. The step does not wrap past its counter width within one test. Under these assumptions the in-range bound on `idx_o` and the bound of the element number by the shape total are meaningful. The bench changes configuration only after the pipeline has drained, and it draws lengths from 1..64. It keeps the start steps and run lengths well below 1024. The bench also checks randomly drawn shapes, codes, offsets and bases against a reference that finds the coordinates by walking the nested loops.

// File: rtl/remap_pkg.sv
// Shared types for the element index remapper.
// Assumes three dimensions, named x, y and z.
package remap_pkg;

    typedef enum logic [1:0] {
        AX_X = 2'd0,
        AX_Y = 2'd1,
        AX_Z = 2'd2
    } axis_e;

    // Loop nesting, listed from the innermost loop to the outermost.
    typedef struct packed {
        axis_e inner;
        axis_e middle;
        axis_e outer;
    } nest_t;

    // Turns a permutation code into a nesting. Unused codes fall back to x,y,z.
    function automatic nest_t decode_order(input logic [2:0] code);
        nest_t n;
        case (code)
            3'b001:  n = '{inner: AX_X, middle: AX_Z, outer: AX_Y};
            3'b010:  n = '{inner: AX_Y, middle: AX_X, outer: AX_Z};
            3'b011:  n = '{inner: AX_Y, middle: AX_Z, outer: AX_X};
            3'b100:  n = '{inner: AX_Z, middle: AX_X, outer: AX_Y};
            3'b101:  n = '{inner: AX_Z, middle: AX_Y, outer: AX_X};
            default: n = '{inner: AX_X, middle: AX_Y, outer: AX_Z};
        endcase
        return n;
    endfunction

endpackage

// File: rtl/remap_step_ctr.sv
// Step counter for the remapper. It loads a step for a restart or advances
// by one, and it raises fire_o for one cycle after each request.
// Assumes load has priority over advance. The counter wraps at 2**STEP_W.
module remap_step_ctr #(
    parameter int STEP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic [STEP_W-1:0] load_step_i,
    output logic [STEP_W-1:0] step_o,
    output logic              fire_o
);

    // Update the step and note that a request was taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_o <= '0;
            fire_o <= 1'b0;
        end else begin
            fire_o <= load_i | adv_i;
            if (load_i)
                step_o <= load_step_i;
            else if (adv_i)
                step_o <= step_o + STEP_W'(1);
        end
    end

    // R13
    step_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> step_o == $past(load_step_i));

    // R13
    step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> step_o == $past(step_o) + STEP_W'(1));

    // R2
    fire_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i || adv_i) |=> fire_o);

    // R2
    fire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i || adv_i) |=> !fire_o);

endmodule

// File: rtl/remap_order.sv
// Orders the three dimension sizes from the innermost loop to the
// outermost, as the permutation code selects, and exports the nesting.
// Assumes each size field holds the size minus one.
module remap_order
    import remap_pkg::*;
#(
    parameter int DIM_W  = 3,
    localparam int SIZE_W = DIM_W + 1
) (
    input  logic [DIM_W-1:0]       xdim_i,
    input  logic [DIM_W-1:0]       ydim_i,
    input  logic [DIM_W-1:0]       zdim_i,
    input  logic [2:0]             perm_i,
    output nest_t                  nest_o,
    output logic [2:0][SIZE_W-1:0] sizes_o
);

    logic [SIZE_W-1:0] xsz, ysz, zsz;

    // Expand each stored field into a real size.
    always_comb begin
        xsz = {1'b0, xdim_i} + SIZE_W'(1);
        ysz = {1'b0, ydim_i} + SIZE_W'(1);
        zsz = {1'b0, zdim_i} + SIZE_W'(1);
    end

    assign nest_o = decode_order(perm_i);

    // Pick the size of each loop level, level 0 being the innermost.
    for (genvar lv = 0; lv < 3; lv++) begin : g_level
        axis_e ax;
        assign ax = (lv == 0) ? nest_o.inner :
                    (lv == 1) ? nest_o.middle : nest_o.outer;
        assign sizes_o[lv] = (ax == AX_X) ? xsz :
                             (ax == AX_Y) ? ysz : zsz;
    end

endmodule

// File: rtl/remap_coord.sv
// Folds the step into the shape, splits it into per-level coordinates
// (innermost counting fastest) and rebuilds a row-major element number
// x + X*y + X*Y*z.
// Assumes every size is at least one, so no divisor is zero.
module remap_coord
    import remap_pkg::*;
#(
    parameter int DIM_W  = 3,
    parameter int STEP_W = 10,
    localparam int SIZE_W = DIM_W + 1,
    localparam int TOT_W  = 3 * SIZE_W,
    localparam int CW     = (STEP_W > TOT_W) ? STEP_W : TOT_W
) (
    input  logic [STEP_W-1:0]      step_i,
    input  logic [DIM_W-1:0]       xdim_i,
    input  logic [DIM_W-1:0]       ydim_i,
    input  nest_t                  nest_i,
    input  logic [2:0][SIZE_W-1:0] sizes_i,
    output logic [CW-1:0]          lin_o,
    output logic [CW-1:0]          total_o
);

    logic [CW-1:0] s0, s1, s2, folded, q;
    logic [CW-1:0] c0, c1, c2, cx, cy, cz, xs, ys;

    // Total element count and the step folded into it.
    always_comb begin
        s0      = CW'(sizes_i[0]);
        s1      = CW'(sizes_i[1]);
        s2      = CW'(sizes_i[2]);
        total_o = s0 * s1 * s2;
        folded  = CW'(step_i) % total_o;
    end

    // Split the folded step into the inner, middle and outer counts.
    always_comb begin
        c0 = folded % s0;
        q  = folded / s0;
        c1 = q % s1;
        c2 = q / s1;
    end

    // Route each level count back to its own axis.
    always_comb begin
        cx = '0;
        cy = '0;
        cz = '0;
        case (nest_i.inner)
            AX_X:    cx = c0;
            AX_Y:    cy = c0;
            default: cz = c0;
        endcase
        case (nest_i.middle)
            AX_X:    cx = c1;
            AX_Y:    cy = c1;
            default: cz = c1;
        endcase
        case (nest_i.outer)
            AX_X:    cx = c2;
            AX_Y:    cy = c2;
            default: cz = c2;
        endcase
    end

    // Rebuild the row-major element number, x fastest.
    always_comb begin
        xs    = CW'(xdim_i) + CW'(1);
        ys    = CW'(ydim_i) + CW'(1);
        lin_o = cx + xs * (cy + ys * cz);
    end

endmodule

// File: rtl/elem_remap.sv
// Multi-dimensional element index remapper, top level.
// Stage 1 is the step counter. Stage 2 registers the offset, length-folded
// index and the register-file overrun flag.
// Assumes the configuration is steady while requests are in flight and
// maxlen_i is never zero.
module elem_remap
    import remap_pkg::*;
#(
    parameter int DIM_W  = 3,
    parameter int STEP_W = 10,
    parameter int IDX_W  = 6,
    parameter int REG_W  = 7,
    parameter int NREGS  = 64,
    localparam int SIZE_W = DIM_W + 1,
    localparam int TOT_W  = 3 * SIZE_W,
    localparam int CW     = (STEP_W > TOT_W) ? STEP_W : TOT_W,
    localparam int SUM_W  = ((REG_W > IDX_W) ? REG_W : IDX_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              advance_i,
    input  logic [STEP_W-1:0] load_step_i,
    input  logic [DIM_W-1:0]  xdim_i,
    input  logic [DIM_W-1:0]  ydim_i,
    input  logic [DIM_W-1:0]  zdim_i,
    input  logic [2:0]        perm_i,
    input  logic [IDX_W-1:0]  offset_i,
    input  logic [IDX_W:0]    maxlen_i,
    input  logic [REG_W-1:0]  base_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              valid_o,
    output logic              overrun_o
);

    logic [STEP_W-1:0]      step;
    logic                   fire;
    nest_t                  nest;
    logic [2:0][SIZE_W-1:0] sizes;
    logic [CW-1:0]          lin, total;
    logic [CW:0]            shifted, folded;
    logic [IDX_W-1:0]       idx_next;
    logic                   ovr_next;

    remap_step_ctr #(.STEP_W(STEP_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .adv_i       (advance_i),
        .load_step_i (load_step_i),
        .step_o      (step),
        .fire_o      (fire)
    );

    remap_order #(.DIM_W(DIM_W)) u_order (
        .xdim_i  (xdim_i),
        .ydim_i  (ydim_i),
        .zdim_i  (zdim_i),
        .perm_i  (perm_i),
        .nest_o  (nest),
        .sizes_o (sizes)
    );

    remap_coord #(.DIM_W(DIM_W), .STEP_W(STEP_W)) u_coord (
        .step_i  (step),
        .xdim_i  (xdim_i),
        .ydim_i  (ydim_i),
        .nest_i  (nest),
        .sizes_i (sizes),
        .lin_o   (lin),
        .total_o (total)
    );

    // Add the offset, fold into the vector length, test the register bound.
    always_comb begin
        shifted  = {1'b0, lin} + (CW+1)'(offset_i);
        folded   = (maxlen_i == '0) ? '0 : shifted % (CW+1)'(maxlen_i);
        idx_next = IDX_W'(folded);
        ovr_next = (SUM_W'(base_i) + SUM_W'(idx_next)) > SUM_W'(NREGS - 1);
    end

    // Register the result of a taken request and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_o     <= '0;
            overrun_o <= 1'b0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= fire;
            if (fire) begin
                idx_o     <= idx_next;
                overrun_o <= ovr_next;
            end
        end
    end

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && maxlen_i != '0) |-> ({1'b0, idx_o} < maxlen_i));

    // R5
    lin_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (lin < total));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> valid_o);

    // R12
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ($stable(idx_o) && $stable(overrun_o) && !valid_o));

endmodule

// File: tb/test_elem_remap.sv
`timescale 1ns/1ps
module test_elem_remap;

    localparam int NREGS = 64;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       load_i, advance_i;
    logic [9:0] load_step_i;
    logic [2:0] xdim_i, ydim_i, zdim_i, perm_i;
    logic [5:0] offset_i;
    logic [6:0] maxlen_i;
    logic [6:0] base_i;
    logic [5:0] idx_o;
    logic       valid_o, overrun_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int got_idx[64];
    int got_ovr[64];
    int got_vld[64];

    elem_remap i_elem_remap (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .advance_i(advance_i),
        .load_step_i(load_step_i), .xdim_i(xdim_i), .ydim_i(ydim_i),
        .zdim_i(zdim_i), .perm_i(perm_i), .offset_i(offset_i),
        .maxlen_i(maxlen_i), .base_i(base_i), .idx_o(idx_o),
        .valid_o(valid_o), .overrun_o(overrun_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference: walk the nested loops in the chosen order up to the step.
    function automatic int ref_idx(input int step, input int xd, input int yd,
                                   input int zd, input int perm, input int off,
                                   input int mlen);
        int sz[3];
        int ord[3];
        int co[3];
        int target;
        int n;
        int lin;
        sz[0] = xd + 1; sz[1] = yd + 1; sz[2] = zd + 1;
        case (perm)
            1: ord = '{0, 2, 1};
            2: ord = '{1, 0, 2};
            3: ord = '{1, 2, 0};
            4: ord = '{2, 0, 1};
            5: ord = '{2, 1, 0};
            default: ord = '{0, 1, 2};
        endcase
        target = step % (sz[0] * sz[1] * sz[2]);
        n = 0;
        co = '{0, 0, 0};
        for (int o = 0; o < sz[ord[2]]; o++)
            for (int m = 0; m < sz[ord[1]]; m++)
                for (int i = 0; i < sz[ord[0]]; i++) begin
                    if (n == target) begin
                        co[ord[0]] = i; co[ord[1]] = m; co[ord[2]] = o;
                    end
                    n++;
                end
        lin = co[0] + sz[0] * (co[1] + sz[1] * co[2]);
        return (lin + off) % mlen;
    endfunction

    task automatic set_cfg(input int xd, input int yd, input int zd, input int pm,
                           input int off, input int mlen, input int base);
        xdim_i = 3'(xd); ydim_i = 3'(yd); zdim_i = 3'(zd); perm_i = 3'(pm);
        offset_i = 6'(off); maxlen_i = 7'(mlen); base_i = 7'(base);
    endtask

    // Load start, then advance n-1 times back to back; capture each result.
    task automatic run_seq(input int start, input int n);
        for (int k = 0; k < n + 2; k++) begin
            if (k >= 2) begin
                got_idx[k-2] = int'(idx_o);
                got_ovr[k-2] = int'(overrun_o);
                got_vld[k-2] = int'(valid_o);
            end
            load_i      = (k == 0);
            advance_i   = (k > 0 && k < n);
            load_step_i = 10'(start);
            @(negedge clk);
        end
        load_i = 1'b0; advance_i = 1'b0;
        @(negedge clk);
    endtask

    // Compare a captured run against the reference for the current config.
    task automatic check_ref(input string req, input int start, input int n);
        for (int k = 0; k < n; k++) begin
            check(req, got_idx[k], ref_idx(start + k, xdim_i, ydim_i, zdim_i,
                                           perm_i, offset_i, maxlen_i));
            check("R2 valid", got_vld[k], 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        int held;
        seed_dummy = $urandom(32'd20240611);
        rst_n = 1'b0; load_i = 1'b0; advance_i = 1'b0; load_step_i = '0;
        set_cfg(0, 0, 0, 0, 0, 64, 0);
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(valid_o), 0);
        check("R1 idx in reset", int'(idx_o), 0);
        check("R1 overrun in reset", int'(overrun_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 valid after reset", int'(valid_o), 0);
        check("R1 idx after reset", int'(idx_o), 0);

        // R2 latency and R12 hold: one isolated load of step 5.
        set_cfg(7, 0, 0, 0, 0, 64, 0);
        load_i = 1'b1; load_step_i = 10'd5;
        @(negedge clk);
        load_i = 1'b0;
        check("R2 not yet valid after one edge", int'(valid_o), 0);
        @(negedge clk);
        check("R2 valid after two edges", int'(valid_o), 1);
        check("R2 result", int'(idx_o), 5);
        @(negedge clk);
        check("R2 valid one cycle only", int'(valid_o), 0);
        held = int'(idx_o);
        repeat (3) @(negedge clk);
        check("R12 idx held", int'(idx_o), held);
        check("R12 valid stays low", int'(valid_o), 0);

        // R9: 4x4 with y innermost, length 4.
        set_cfg(3, 3, 0, 2, 0, 4, 0);
        run_seq(0, 16);
        for (int k = 0; k < 16; k++) check("R9 4x4 y inner", got_idx[k], k / 4);

        // R10: 4x1 with x innermost cycles 0..3.
        set_cfg(3, 0, 0, 0, 0, 16, 0);
        run_seq(0, 16);
        for (int k = 0; k < 16; k++) check("R10 4x1 cycle", got_idx[k], k % 4);

        // R7 and R3: identity order with wrap at 24 and fold at 16.
        set_cfg(3, 2, 1, 0, 0, 16, 0);
        run_seq(0, 30);
        for (int k = 0; k < 30; k++) check("R7 identity order", got_idx[k], (k % 24) % 16);

        // R3: 2x2x2 shape wraps after 8 steps.
        set_cfg(1, 1, 1, 0, 0, 64, 0);
        run_seq(8, 2);
        check("R3 wrap step 8", got_idx[0], 0);
        check("R3 wrap step 9", got_idx[1], 1);

        // R4: codes 110 and 111 act as 000.
        for (int pc = 6; pc < 8; pc++) begin
            set_cfg(2, 3, 1, pc, 0, 64, 0);
            run_seq(0, 24);
            for (int k = 0; k < 24; k++) check("R4 spare code", got_idx[k], k);
        end

        // R8: two unit dimensions keep step order for every code.
        for (int pc = 0; pc < 8; pc++) begin
            set_cfg(0, 5, 0, pc, 0, 64, 0);
            run_seq(0, 8);
            for (int k = 0; k < 8; k++) check("R8 unit dims", got_idx[k], k % 6);
        end

        // R5: z innermost, sizes 2,3,4; step 1 sits at z=1 -> 2*3 = 6.
        set_cfg(1, 2, 3, 5, 0, 64, 0);
        run_seq(0, 4);
        check("R5 zyx step 0", got_idx[0], 0);
        check("R5 zyx step 1", got_idx[1], 6);
        check("R5 zyx step 3", got_idx[3], 18);

        // R6: offset then fold.
        set_cfg(7, 0, 0, 0, 5, 10, 0);
        run_seq(0, 10);
        for (int k = 0; k < 10; k++) check("R6 offset fold", got_idx[k], ((k % 8) + 5) % 10);

        // R11: base 60 overruns from index 4.
        set_cfg(7, 0, 0, 0, 0, 64, 60);
        run_seq(0, 8);
        for (int k = 0; k < 8; k++) begin
            check("R11 idx", got_idx[k], k);
            check("R11 overrun", got_ovr[k], (60 + k > NREGS - 1) ? 1 : 0);
        end

        // R13: load wins over advance; a direct load matches the reference.
        set_cfg(3, 2, 1, 3, 7, 50, 0);
        load_i = 1'b1; advance_i = 1'b1; load_step_i = 10'd37;
        @(negedge clk);
        load_i = 1'b0; advance_i = 1'b0;
        @(negedge clk);
        check("R13 load priority", int'(idx_o), ref_idx(37, 3, 2, 1, 3, 7, 50));
        run_seq(37, 3);
        check_ref("R13 restart", 37, 3);

        // Random shapes, codes, offsets, lengths and bases (R4 R5 R6 R11).
        for (int t = 0; t < 60; t++) begin
            int st;
            int bs;
            bs = int'($urandom_range(0, 100));
            set_cfg(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                    int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                    int'($urandom_range(0, 63)), int'($urandom_range(1, 64)), bs);
            st = int'($urandom_range(0, 900));
            run_seq(st, 8);
            check_ref("R4 R5 R6 random", st, 8);
            for (int k = 0; k < 8; k++)
                check("R11 random overrun", got_ovr[k], (bs + got_idx[k] > NREGS - 1) ? 1 : 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule